// File: doc/BRIEF.md
# Oversampled SPI Slave with Streaming FIFOs

This block is a mode-0 SPI slave, MSB first, with a parameterised word width. Every flop runs on the system clock. The three bus inputs (serial clock, slave data in and active-low select) are first brought into the system clock domain through two-flop synchronizers. An event sequencer watches the synchronized serial clock. Each rising edge gives a one-cycle capture strobe and each falling edge gives a one-cycle advance strobe.

A bit index records the position inside the current word. Received bits build up in a shift register. Each completed word moves into a one-entry holding register, which a ready/valid streaming source offers to the system. In the other direction, a ready/valid streaming sink fills a small transmit FIFO. That FIFO parallel-loads the transmit shift register whose top bit drives the slave data output. The serial clock must stay at or below about a quarter of the system clock.

Top module: `spi_os_slave`

## Requirements
- R1: After a synchronous reset, `src_valid` is 0, `snk_ready` is 1, `overrun` is 0 and `miso` is 0.
- R2: Bits on `mosi` are taken on rising `sclk` edges while `ss_n` is low, MSB first. After the last of WORD_W bits, the assembled word appears on `src_data` with `src_valid` set to 1.
- R3: While `src_valid` is 1 and `src_ready` is 0, `src_valid` stays 1 and `src_data` keeps its value. A cycle with both set to 1 removes the word, and `src_valid` then goes to 0 unless a new word is written in that same cycle.
- R4: Words accepted on the sink go out on `miso` MSB first, in the order they were written. The first word is loaded when `ss_n` falls. Each later word is loaded on the falling `sclk` edge that follows the last bit of the word before it. Each next bit appears within three system clocks of a falling `sclk` edge.
- R5: The transmit FIFO holds TX_DEPTH words. `snk_ready` is 0 while it is full, and a `snk_valid` cycle while `snk_ready` is 0 stores nothing.
- R6: If the transmit FIFO is empty when a word must be loaded, that word goes out as all zeros.
- R7: If a word completes while the holding register is full and is not being read, the new word is dropped, the held word is kept, and `overrun` goes to 1 and stays there until reset.
- R8: Raising `ss_n` in the middle of a word discards the bits received so far. The next selection starts again at bit 0.
- R9: `sclk` edges while `ss_n` is high neither capture nor shift. No word is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| mosi | input | 1 | Serial data from the master (asynchronous) |
| ss_n | input | 1 | Slave select, active low (asynchronous) |
| miso | output | 1 | Serial data to the master |
| src_data | output | WORD_W | Received word |
| src_valid | output | 1 | Received word available |
| src_ready | input | 1 | Consumer takes the received word |
| snk_data | input | WORD_W | Word to transmit |
| snk_valid | input | 1 | Producer offers a word to transmit |
| snk_ready | output | 1 | Transmit FIFO has room |
| overrun | output | 1 | Sticky flag: a received word was dropped |

## Verification
The assertions rely on two things. First, the serial clock has each high and low phase at least two system clocks long, so every synchronized edge gives exactly one strobe. Second, `mosi` and `ss_n` change only together with a falling `sclk` or while `sclk` is idle low. The bench master meets this by holding each `sclk` phase for two system clocks and changing `mosi` only with falling edges. It waits six clocks after moving `ss_n` before the first edge.

Because the synchronizer adds delay, `miso` settles about three system clocks after a falling edge. The master therefore reads `miso` at the end of the high phase, just before it drives `sclk` low.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

  // Depth of every input synchronizer chain.
  localparam int SYNC_STAGES = 2;

  // One-cycle strobes derived from the synchronized serial bus.
  typedef struct packed {
    logic start;   // select has just gone active
    logic sample;  // rising serial clock edge, select active
    logic shift;   // falling serial clock edge, select active
  } spi_evt_t;

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  import spi_os_pkg::*;

  logic [N-1:0] stage [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= RST_VAL;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[SYNC_STAGES-1];
endmodule

// File: rtl/spi_os_seq.sv
module spi_os_seq (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_sclk,
  input  logic                  s_ssn,
  output spi_os_pkg::spi_evt_t  evt
);
  logic sclk_q, ssn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      ssn_q  <= 1'b1;
    end else begin
      sclk_q <= s_sclk;
      ssn_q  <= s_ssn;
    end
  end

  // Mode 0: capture on rising, advance on falling edges.
  always_comb begin
    evt.start  = ~s_ssn & ssn_q;
    evt.sample = ~s_ssn &  s_sclk & ~sclk_q;
    evt.shift  = ~s_ssn & ~s_sclk &  sclk_q;
  end
endmodule

// File: rtl/spi_os_fifo.sv
module spi_os_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int WORD_W   = 8,
  parameter int TX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic [WORD_W-1:0] src_data,
  output logic              src_valid,
  input  logic              src_ready,
  input  logic [WORD_W-1:0] snk_data,
  input  logic              snk_valid,
  output logic              snk_ready,
  output logic              overrun
);
  import spi_os_pkg::*;

  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [2:0]        bus_sync;
  logic              s_sclk, s_mosi, s_ssn;
  spi_evt_t          evt;
  logic [CNT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] rx_sh, rx_word, hold_q, tx_sh, fifo_head, load_val;
  logic              hold_full, word_done, pop, tx_load, fifo_empty, fifo_full;

  spi_os_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n, sclk, mosi}),
    .q   (bus_sync)
  );
  assign {s_ssn, s_sclk, s_mosi} = bus_sync;

  spi_os_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .s_sclk (s_sclk),
    .s_ssn  (s_ssn),
    .evt    (evt)
  );

  // Bit index: held at zero while deselected, wraps after the last bit.
  always_ff @(posedge clk) begin
    if (rst || s_ssn)  bit_idx <= '0;
    else if (evt.sample) bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
  end

  // Receive path.
  assign rx_word   = {rx_sh[WORD_W-2:0], s_mosi};
  assign word_done = evt.sample & (bit_idx == LAST_BIT);
  assign pop       = hold_full & src_ready;

  always_ff @(posedge clk) begin
    if (rst) rx_sh <= '0;
    else if (evt.sample) rx_sh <= rx_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (pop) hold_full <= 1'b0;
      if (word_done) begin
        if (!hold_full || pop) begin
          hold_q    <= rx_word;
          hold_full <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

  assign src_data  = hold_q;
  assign src_valid = hold_full;

  // Transmit path.
  spi_os_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (snk_valid),
    .wr_data (snk_data),
    .rd_en   (tx_load),
    .rd_data (fifo_head),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );
  assign snk_ready = ~fifo_full;

  assign tx_load  = evt.start | (evt.shift & (bit_idx == '0));
  assign load_val = fifo_empty ? '0 : fifo_head;

  always_ff @(posedge clk) begin
    if (rst)           tx_sh <= '0;
    else if (tx_load)  tx_sh <= load_val;
    else if (evt.shift) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
  end

  assign miso = tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_os_slave_chk.sv
module spi_os_slave_chk #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              src_valid,
  input logic              src_ready,
  input logic [WORD_W-1:0] src_data,
  input logic              snk_valid,
  input logic              snk_ready,
  input logic              overrun,
  input logic [CNT_W-1:0]  bit_idx
);
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src_valid && !src_ready) |=> (src_valid && $stable(src_data))); // R3

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R7

  AST_OVR_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> src_valid); // R7

  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(snk_ready) |-> $past(snk_valid)); // R5

  AST_WORD_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(src_valid) |-> (bit_idx == '0)); // R2
endmodule

bind spi_os_slave spi_os_slave_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .src_data  (src_data),
  .snk_valid (snk_valid),
  .snk_ready (snk_ready),
  .overrun   (overrun),
  .bit_idx   (bit_idx)
);

// File: tb/spi_os_slave_test.sv
`timescale 1ns/1ps
module spi_os_slave_test;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic         miso;
  logic [W-1:0] src_data;
  logic         src_valid;
  logic         src_ready = 1'b0;
  logic [W-1:0] snk_data = '0;
  logic         snk_valid = 1'b0;
  logic         snk_ready;
  logic         overrun;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_os_slave #(.WORD_W(W), .TX_DEPTH(D)) uut (
    .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] d, output bit took);
    @(negedge clk);
    snk_valid = 1'b1;
    snk_data  = d;
    took      = snk_ready;
    @(negedge clk);
    snk_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [W-1:0] exp);
    @(negedge clk);
    check(req, src_valid, 1'b1);
    check(req, src_data, exp);
    src_ready = 1'b1;
    @(negedge clk);
    src_ready = 1'b0;
    check(req, src_valid, 1'b0);
  endtask

  task automatic select();
    @(negedge clk);
    ss_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic deselect();
    wait_clk(2);
    ss_n = 1'b1;
    wait_clk(6);
  endtask

  // Mode 0 master bits; MISO is read at the end of the high phase.
  task automatic send_bits(input logic [W-1:0] mo, input int nb, output logic [W-1:0] mi);
    mi = '0;
    for (int i = W-1; i >= W-nb; i--) begin
      @(negedge clk);
      mosi = mo[i];
      wait_clk(2);
      sclk = 1'b1;
      wait_clk(2);
      mi[i] = miso;
      sclk = 1'b0;
    end
  endtask

  task automatic word_pop(input string req, input logic [W-1:0] mo,
                          input logic [W-1:0] exp_mi);
    logic [W-1:0] mi;
    send_bits(mo, W, mi);
    check(req, mi, exp_mi);
    wait_clk(4);
    pop_expect(req, mo);
  endtask

  task automatic t_reset();
    wait_clk(1);
    check("R1 src_valid", src_valid, 1'b0);
    check("R1 snk_ready", snk_ready, 1'b1);
    check("R1 overrun", overrun, 1'b0);
    check("R1 miso", miso, 1'b0);
  endtask

  task automatic t_duplex();
    bit ok;
    push(8'hA5, ok); check("R4 push", ok, 1'b1);
    push(8'h3C, ok); check("R4 push", ok, 1'b1);
    select();
    word_pop("R2 R4 word0", 8'h81, 8'hA5);
    word_pop("R2 R4 word1", 8'h7E, 8'h3C);
    deselect();
  endtask

  task automatic t_underrun();
    select();
    word_pop("R6 empty tx", 8'h55, 8'h00);
    deselect();
  endtask

  task automatic t_full();
    bit ok;
    for (int i = 0; i < D; i++) begin
      push(8'h10 + 8'(i), ok);
      check("R5 accept", ok, 1'b1);
    end
    check("R5 not ready", snk_ready, 1'b0);
    push(8'hEE, ok);
    check("R5 refused", ok, 1'b0);
    select();
    for (int i = 0; i < D; i++) word_pop("R5 R4 order", 8'hC0 + 8'(i), 8'h10 + 8'(i));
    word_pop("R5 dropped write", 8'h5A, 8'h00);
    deselect();
    check("R5 ready again", snk_ready, 1'b1);
  endtask

  task automatic t_abort();
    logic [W-1:0] mi;
    select();
    send_bits(8'hFF, 4, mi);
    deselect();
    check("R8 no partial word", src_valid, 1'b0);
    select();
    word_pop("R8 restart", 8'h96, 8'h00);
    deselect();
  endtask

  task automatic t_idle();
    @(negedge clk);
    mosi = 1'b1;
    for (int i = 0; i < 2*W; i++) begin
      wait_clk(2); sclk = 1'b1;
      wait_clk(2); sclk = 1'b0;
    end
    wait_clk(6);
    check("R9 idle clocks", src_valid, 1'b0);
    select();
    word_pop("R9 aligned after idle", 8'hC3, 8'h00);
    deselect();
  endtask

  task automatic t_overrun();
    logic [W-1:0] mi;
    select();
    send_bits(8'h11, W, mi);
    send_bits(8'h22, W, mi);
    deselect();
    check("R7 overrun", overrun, 1'b1);
    check("R3 held valid", src_valid, 1'b1);
    check("R7 kept word", src_data, 8'h11);
    wait_clk(10);
    check("R3 still held", src_data, 8'h11);
    pop_expect("R7 R3 pop", 8'h11);
    check("R7 sticky", overrun, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    t_reset();
    t_duplex();
    t_underrun();
    t_full();
    t_abort();
    t_idle();
    t_overrun();
    finish_run();
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end
endmodule